// File: doc/BRIEF.md
# Lane Inversion Sweep Pointer Rotator

This block holds the receive inversion mask of a 14-lane serial link while the link runs a built-in self-test. Each mask bit flips the polarity of one receive lane. A test sequencer writes a starting pattern into the mask. With auto-sweep enabled, each step strobe then moves the pattern by one position, so the inverted lanes walk across the port over time.

There are two sweep topologies.

- **Full ring.** The mask rotates left as one 14-bit ring: lane 0 feeds lane 1, and so on up to lane 13, which wraps to lane 0. Lane 13 is always part of the ring, even on a receiver that has no physical lane 13.
- **Grouped.** The port is split into the groups {4..0}, {9..5} and {13..10}. A mapping input picks lanes 4..0 or lanes 9..5 as the reference group. On each step the reference rotates by one place modulo 5, and the result is copied into all three groups. All groups therefore follow the same pattern. The four-lane group {13..10} takes the low four bits of the five-bit result; the fifth bit is dropped.

Top module: `lane_inv_sweep`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `invMask` is all zeros.
- R2: When `loadEn` is high at a clock edge, `invMask` equals `loadMask` after that edge. This holds in every mode, whatever `autoEn` is.
- R3: When `loadEn` and a qualified step occur at the same edge, the load wins. `invMask` equals `loadMask` and is not rotated.
- R4: When `autoEn` is 0, `invMask` holds its value at every edge without a load, even when `stepStrobe` is high.
- R5: When `autoEn` is 1 and `stepStrobe` is 0, `invMask` holds its value at every edge without a load.
- R6: With `fullSweep`=1, each qualified step gives new bit (i+1) mod 14 = old bit i, for i = 0..13. Old bit 13 moves to bit 0.
- R7: With `fullSweep`=0 and `mapUpper`=0, let p = old bits 4..0 and q = {p[3:0], p[4]}. After a step, bits 4..0 = q, bits 9..5 = q, and bits 13..10 = q[3:0].
- R8: With `fullSweep`=0 and `mapUpper`=1, p = old bits 9..5. The rest of the rule is as in R7.
- R9: A qualified step needs `autoEn`=1, `stepStrobe`=1 and `loadEn`=0 at the same edge. Each qualified step moves the pattern by exactly one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fullSweep | input | 1 | 1 selects the full 14-lane ring; 0 selects grouped modulo-5 rotation |
| mapUpper | input | 1 | Reference group in grouped mode: 0 selects lanes 4..0, 1 selects lanes 9..5 |
| autoEn | input | 1 | Auto-sweep enable |
| loadEn | input | 1 | Write strobe for the starting pattern |
| loadMask | input | 14 | Pattern written when `loadEn` is high |
| stepStrobe | input | 1 | Advance request, one position per strobe |
| invMask | output | 14 | Per-lane receive inversion mask |

## Verification
The hardest case to reach is a grouped step where the non-reference groups hold bits that differ from the reference. After any grouped step all three groups are equal, so the overwrite can only be seen right after a load or a run of full-ring steps. The random stimulus therefore reloads arbitrary patterns often and mixes the two topologies. Directed cases add a reference in lanes 9..5 that differs from lanes 4..0, and a load that coincides with a step while auto-sweep is on.

// File: rtl/lane_inv_sweep_pkg.sv
package lane_inv_sweep_pkg;
  localparam int NUM_LANES = 14;
  localparam int GROUP_W   = 5;

  typedef struct packed {
    logic load;
    logic stepFull;
    logic stepGroup;
    logic refUpper;
  } sweepCmd_t;
endpackage

// File: rtl/lane_inv_sweep_ctrl.sv
module lane_inv_sweep_ctrl
  import lane_inv_sweep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fullSweep,
  input  logic      mapUpper,
  input  logic      autoEn,
  input  logic      loadEn,
  input  logic      stepStrobe,
  output sweepCmd_t cmd
);
  logic advance;

  // A step is qualified only when sweeping is on, a strobe is present and no load competes.
  always_comb begin
    advance       = autoEn && stepStrobe && !loadEn;
    cmd.load      = loadEn;
    cmd.stepFull  = advance && fullSweep;
    cmd.stepGroup = advance && !fullSweep;
    cmd.refUpper  = mapUpper;
  end

  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !autoEn |-> !(cmd.stepFull || cmd.stepGroup));  // R4

  AST_LOAD_BEATS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> !(cmd.stepFull || cmd.stepGroup));  // R3

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.load, cmd.stepFull, cmd.stepGroup}));  // R9
endmodule

// File: rtl/lane_inv_sweep_datapath.sv
module lane_inv_sweep_datapath
  import lane_inv_sweep_pkg::*;
#(
  parameter int LANES = NUM_LANES,
  parameter int GW    = GROUP_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  sweepCmd_t        cmd,
  input  logic [LANES-1:0] loadMask,
  output logic [LANES-1:0] invMask
);
  localparam int NUM_GROUPS = (LANES + GW - 1) / GW;

  logic [LANES-1:0] maskQ;
  logic [LANES-1:0] ringNext;
  logic [LANES-1:0] groupNext;
  logic [GW-1:0]    refGrp;
  logic [GW-1:0]    refRot;

  // Full ring: every lane, including lane 13, moves up one place and the top lane wraps to lane 0.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      ringNext[(i + 1) % LANES] = maskQ[i];
    end
  end

  // Grouped: rotate the chosen reference group modulo GW and copy it into every group.
  always_comb begin
    refGrp = cmd.refUpper ? maskQ[GW +: GW] : maskQ[0 +: GW];
    refRot = {refGrp[GW-2:0], refGrp[GW-1]};
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    localparam int LO = g * GW;
    localparam int W  = (LANES - LO < GW) ? (LANES - LO) : GW;
    assign groupNext[LO +: W] = refRot[W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (cmd.load)      maskQ <= loadMask;
    else if (cmd.stepFull)  maskQ <= ringNext;
    else if (cmd.stepGroup) maskQ <= groupNext;
  end

  assign invMask = maskQ;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> invMask == $past(loadMask));  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.load || cmd.stepFull || cmd.stepGroup) |=> $stable(invMask));  // R5

  AST_RING_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepFull |=> $countones(invMask) == $countones($past(invMask)));  // R6

  AST_GROUPS_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepGroup |=> (invMask[0 +: GW] == invMask[GW +: GW])
                   && (invMask[LANES-1:2*GW] == invMask[LANES-1-2*GW:0]));  // R7
endmodule

// File: rtl/lane_inv_sweep.sv
module lane_inv_sweep
  import lane_inv_sweep_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fullSweep,
  input  logic                 mapUpper,
  input  logic                 autoEn,
  input  logic                 loadEn,
  input  logic [NUM_LANES-1:0] loadMask,
  input  logic                 stepStrobe,
  output logic [NUM_LANES-1:0] invMask
);
  sweepCmd_t cmd;

  lane_inv_sweep_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fullSweep  (fullSweep),
    .mapUpper   (mapUpper),
    .autoEn     (autoEn),
    .loadEn     (loadEn),
    .stepStrobe (stepStrobe),
    .cmd        (cmd)
  );

  lane_inv_sweep_datapath #(
    .LANES (NUM_LANES),
    .GW    (GROUP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .loadMask (loadMask),
    .invMask  (invMask)
  );
endmodule

// File: tb/lane_inv_sweep_tb.sv
module lane_inv_sweep_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fullSweep = 1'b0;
  logic        mapUpper = 1'b0;
  logic        autoEn = 1'b0;
  logic        loadEn = 1'b0;
  logic [13:0] loadMask = '0;
  logic        stepStrobe = 1'b0;
  logic [13:0] invMask;

  int compared = 0;
  int mismatched = 0;
  logic [13:0] expMask = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_inv_sweep u_dut (
    .clk(clk), .rstN(rstN), .fullSweep(fullSweep), .mapUpper(mapUpper),
    .autoEn(autoEn), .loadEn(loadEn), .loadMask(loadMask),
    .stepStrobe(stepStrobe), .invMask(invMask)
  );

  // Reference model: the mask value after one clock edge, written from the requirements.
  function automatic logic [13:0] modelNext(logic [13:0] m, logic full, logic up,
                                            logic au, logic ld, logic st, logic [13:0] lm);
    logic [4:0] p, q;
    if (ld) return lm;
    if (!(au && st)) return m;
    if (full) return {m[12:0], m[13]};
    p = up ? m[9:5] : m[4:0];
    q = {p[3:0], p[4]};
    return {q[3:0], q, q};
  endfunction

  task automatic check(string tag);
    compared++;
    if (invMask !== expMask) begin
      mismatched++;
      $display("FAIL %s: invMask=%h expected=%h", tag, invMask, expMask);
    end
  endtask

  // Drive inputs on the falling edge, let one rising edge pass, then compare on the next falling edge.
  task automatic cycle(logic full, logic up, logic au, logic ld, logic st,
                       logic [13:0] lm, string tag);
    fullSweep = full; mapUpper = up; autoEn = au; loadEn = ld; stepStrobe = st; loadMask = lm;
    expMask = modelNext(expMask, full, up, au, ld, st, lm);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    expMask = '0;
    check("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R2: the load lands in grouped mode as well as ring mode
    cycle(0, 0, 0, 1, 0, 14'h2A5C, "R2 load grouped");
    cycle(1, 1, 1, 1, 0, 14'h0001, "R2 load ring");

    // R4: a strobe with auto-sweep off does nothing
    cycle(1, 0, 0, 0, 1, 14'h3FFF, "R4 strobe ignored");

    // R6: fourteen ring steps carry lane 13 through lane 0 and back to the start
    for (int i = 0; i < 14; i++) cycle(1, 0, 1, 0, 1, 14'h0, "R6 ring step");
    cycle(1, 0, 1, 0, 0, 14'h0, "R5 no strobe");

    // R3: a load arriving together with a step wins
    cycle(1, 0, 1, 1, 1, 14'h1234, "R3 load beats step");

    // R7/R8: the reference group differs from the others
    cycle(0, 0, 0, 1, 0, 14'h03E1, "R2 preload");
    cycle(0, 0, 1, 0, 1, 14'h0, "R7 lower reference");
    cycle(0, 0, 0, 1, 0, 14'h0141, "R2 preload");
    cycle(0, 1, 1, 0, 1, 14'h0, "R8 upper reference");
    for (int i = 0; i < 5; i++) cycle(0, 1, 1, 0, 1, 14'h0, "R9 grouped step");

    for (int n = 0; n < 3000; n++) begin
      logic full, up, au, ld, st;
      logic [13:0] lm;
      string tag;
      full = 1'($urandom);
      up   = 1'($urandom);
      au   = ($urandom % 4) != 0;
      ld   = ($urandom % 6) == 0;
      st   = ($urandom % 3) != 0;
      lm   = 14'($urandom);
      if (ld && au && st)  tag = "R3 random";
      else if (ld)         tag = "R2 random";
      else if (!au)        tag = "R4 random";
      else if (!st)        tag = "R5 random";
      else if (full)       tag = "R6 random";
      else if (up)         tag = "R8 random";
      else                 tag = "R7 random";
      cycle(full, up, au, ld, st, lm, tag);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule